// File: doc/BRIEF.md
# 32-bit Multiply-Accumulate/Subtract Unit

This unit takes three operands, multiplies the low 32-bit words of the first two, and then adds the low 32 bits of that product to the low 32-bit word of the accumulator operand. When the subtract select is set, it subtracts the product from the accumulator instead. Everything above bit 31 of the product is thrown away. The sum or difference therefore wraps modulo 2^32, and it does not matter whether the operands are read as signed or unsigned.

A mode input chooses how wide the result is. In wide mode, bit 31 of the 32-bit result is copied into all upper bits of the 64-bit output. In narrow mode the 32-bit value is returned as is, with zeros above it.

Operations arrive over a valid/ready handshake. The unit accepts one operation at a time and works on it in steps: each cycle it multiplies the multiplicand by one 8-bit digit of the multiplier. With the default parameters this takes four cycles. One more cycle forms the accumulator sum or difference into a registered result, and a single-cycle valid pulse marks it.

Top module: `mulacc_unit`

## Requirements
- R1: After synchronous reset, `outValid` is 0, `inReady` is 1 and `outResult` is 0.
- R2: `inReady` is 1 only while the unit is idle. An operation is taken on a rising edge where `inValid` and `inReady` are both 1. Inputs presented while `inReady` is 0 have no effect on the pending result.
- R3: `outValid` is high for exactly one cycle. With default parameters it is first seen high 5 clock edges after the accepting edge, which is the step count (32/8 = 4) plus 1.
- R4: With `subSel`=0 the 32-bit result is (acc[31:0] + (a[31:0]*b[31:0] mod 2^32)) mod 2^32.
- R5: With `subSel`=1 the 32-bit result is (acc[31:0] - (a[31:0]*b[31:0] mod 2^32)) mod 2^32.
- R6: Operand bits above bit 31 of `opA`, `opB` and `opAcc` do not change the result.
- R7: With `mode64`=1, `outResult[63:32]` all equal `outResult[31]`. With `mode64`=0, `outResult[63:32]` are 0.
- R8: `outResult` keeps its value until the next result completes.
- R9: A reset asserted while an operation is in progress drops that operation. No `outValid` follows, and `inReady` is 1 after the reset.
- R10: `inReady` is 1 in the same cycle that `outValid` is 1, so a new operation can be accepted on the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation request |
| inReady | output | 1 | Unit idle; request will be taken |
| subSel | input | 1 | 0 = accumulate, 1 = subtract product |
| mode64 | input | 1 | 1 = sign-extend result, 0 = zero-extend |
| opA | input | XLEN | Multiplicand (low word used) |
| opB | input | XLEN | Multiplier (low word used) |
| opAcc | input | XLEN | Accumulator (low word used) |
| outValid | output | 1 | One-cycle result strobe |
| outResult | output | XLEN | Registered result |

## Verification
A fault in the digit-step state would show up at the ports in one of two ways. A step counter that ends too early or too late moves the `outValid` pulse off its fixed 5-edge slot. A wrong shift of the multiplicand or multiplier shows up as a wrong `outResult` at the first completion that uses a nonzero upper multiplier digit. Operand registers that are captured while the unit is busy corrupt the very next result, which the busy-cycle noise exposes. A wrong extension flag shows up in the upper word at the next completion.

// File: rtl/mulacc_pkg.sv
package mulacc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_FIN  = 2'd2
  } mulacc_state_t;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } mulacc_strobe_t;

endpackage

// File: rtl/mulacc_ctrl.sv
module mulacc_ctrl
  import mulacc_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           inValid,
  output logic           inReady,
  output mulacc_strobe_t strb,
  output logic           outValid
);

  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  mulacc_state_t state;
  logic [CNT_W-1:0] stepCnt;

  assign inReady     = (state == ST_IDLE);
  assign strb.load   = inReady && inValid;
  assign strb.step   = (state == ST_MUL);
  assign strb.finish = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      stepCnt  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strb.finish;
      unique case (state)
        ST_IDLE: begin
          if (strb.load) begin
            state   <= ST_MUL;
            stepCnt <= '0;
          end
        end
        ST_MUL: begin
          if (stepCnt == CNT_W'(STEPS - 1)) begin
            state <= ST_FIN;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mulacc_dp.sv
module mulacc_dp
  import mulacc_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int WORD_W  = 32,
  parameter int DIGIT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  mulacc_strobe_t   strb,
  input  logic [XLEN-1:0]  opA,
  input  logic [XLEN-1:0]  opB,
  input  logic [XLEN-1:0]  opAcc,
  input  logic             subSel,
  input  logic             mode64,
  output logic [XLEN-1:0]  result
);

  localparam int PROD_W = WORD_W + DIGIT_W;

  logic [WORD_W-1:0] mcand;
  logic [WORD_W-1:0] mplier;
  logic [WORD_W-1:0] accWord;
  logic [WORD_W-1:0] prodSum;
  logic              subR;
  logic              wideR;

  logic [PROD_W-1:0] digitProd;
  logic [WORD_W-1:0] combWord;
  logic [XLEN-1:0]   resNext;

  // one multiplier digit times the shifted multiplicand, truncated to a word
  assign digitProd = {{DIGIT_W{1'b0}}, mcand} * {{WORD_W{1'b0}}, mplier[DIGIT_W-1:0]};
  assign combWord  = subR ? (accWord - prodSum) : (accWord + prodSum);

  generate
    if (XLEN > WORD_W) begin : g_extend
      assign resNext = wideR ? {{(XLEN-WORD_W){combWord[WORD_W-1]}}, combWord}
                             : {{(XLEN-WORD_W){1'b0}}, combWord};
    end else begin : g_plain
      assign resNext = combWord;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand   <= '0;
      mplier  <= '0;
      accWord <= '0;
      prodSum <= '0;
      subR    <= 1'b0;
      wideR   <= 1'b0;
      result  <= '0;
    end else begin
      if (strb.load) begin
        mcand   <= opA[WORD_W-1:0];
        mplier  <= opB[WORD_W-1:0];
        accWord <= opAcc[WORD_W-1:0];
        prodSum <= '0;
        subR    <= subSel;
        wideR   <= mode64;
      end
      if (strb.step) begin
        prodSum <= prodSum + digitProd[WORD_W-1:0];
        mcand   <= mcand << DIGIT_W;
        mplier  <= mplier >> DIGIT_W;
      end
      if (strb.finish) begin
        result <= resNext;
      end
    end
  end

endmodule

// File: rtl/mulacc_unit.sv
module mulacc_unit
  import mulacc_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int WORD_W  = 32,
  parameter int DIGIT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  output logic            inReady,
  input  logic            subSel,
  input  logic            mode64,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic [XLEN-1:0] opAcc,
  output logic            outValid,
  output logic [XLEN-1:0] outResult
);

  localparam int STEPS = WORD_W / DIGIT_W;

  mulacc_strobe_t strb;

  mulacc_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .strb     (strb),
    .outValid (outValid)
  );

  mulacc_dp #(.XLEN(XLEN), .WORD_W(WORD_W), .DIGIT_W(DIGIT_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .opA    (opA),
    .opB    (opB),
    .opAcc  (opAcc),
    .subSel (subSel),
    .mode64 (mode64),
    .result (outResult)
  );

endmodule

// File: rtl/mulacc_chk.sv
module mulacc_chk #(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32,
  parameter int STEPS  = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            inValid,
  input logic            inReady,
  input logic            outValid,
  input logic [XLEN-1:0] outResult
);

  localparam int LAT_W = $clog2(STEPS + 4) + 1;

  logic             tracking;
  logic [LAT_W-1:0] lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      tracking <= 1'b0;
      lat      <= '0;
    end else if (inValid && inReady) begin
      tracking <= 1'b1;
      lat      <= '0;
    end else if (outValid) begin
      tracking <= 1'b0;
    end else if (tracking) begin
      lat <= lat + 1'b1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!outValid && inReady));

  a_r9_reset_drops: assert property (@(posedge clk) rst |=> (outResult == '0));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> !inReady);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (tracking && (lat == LAT_W'(STEPS + 1))));

  a_r10_ready_with_result: assert property (@(posedge clk) disable iff (rst)
    outValid |-> inReady);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!outValid && !$past(rst)) |-> $stable(outResult));

  generate
    if (XLEN > WORD_W) begin : g_ext_chk
      a_r7_upper_uniform: assert property (@(posedge clk) disable iff (rst)
        outValid |-> ((outResult[XLEN-1:WORD_W] == '0) ||
                      (outResult[XLEN-1:WORD_W] == {(XLEN-WORD_W){outResult[WORD_W-1]}})));
    end
  endgenerate

endmodule

bind mulacc_unit mulacc_chk #(.XLEN(XLEN), .WORD_W(WORD_W), .STEPS(STEPS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .inReady   (inReady),
  .outValid  (outValid),
  .outResult (outResult)
);

// File: tb/mulacc_unit_test.sv
`timescale 1ns/1ps
module mulacc_unit_test;

  localparam int XLEN = 64;
  localparam int LAT  = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            inValid = 1'b0;
  logic            subSel = 1'b0;
  logic            mode64 = 1'b0;
  logic [XLEN-1:0] opA = '0;
  logic [XLEN-1:0] opB = '0;
  logic [XLEN-1:0] opAcc = '0;
  logic            inReady;
  logic            outValid;
  logic [XLEN-1:0] outResult;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk = ~clk;

  mulacc_unit uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .subSel(subSel), .mode64(mode64), .opA(opA), .opB(opB), .opAcc(opAcc),
    .outValid(outValid), .outResult(outResult)
  );

  function automatic logic [63:0] nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                        logic [63:0] acc, logic s, logic w);
    logic [63:0] p;
    logic [31:0] r;
    p = {32'd0, a[31:0]} * {32'd0, b[31:0]};
    r = s ? (acc[31:0] - p[31:0]) : (acc[31:0] + p[31:0]);
    return w ? {{32{r[31]}}, r} : {32'd0, r};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // starts and ends at a negative edge; leaves the bench in the result cycle
  task automatic runOp(logic [63:0] a, logic [63:0] b, logic [63:0] acc,
                       logic s, logic w, string req);
    logic [63:0] exp;
    exp = model(a, b, acc, s, w);
    opA = a; opB = b; opAcc = acc; subSel = s; mode64 = w; inValid = 1'b1;
    check("R2 ready before accept", {63'd0, inReady}, 64'd1);
    @(posedge clk);
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      check("R3 no early valid", {63'd0, outValid}, 64'd0);
      check("R2 busy not ready", {63'd0, inReady}, 64'd0);
      // noise while busy must not reach the result (R2)
      opA = nextRand(); opB = nextRand(); opAcc = nextRand();
      subSel = ~s; mode64 = ~w; inValid = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
    check("R3 valid at latency", {63'd0, outValid}, 64'd1);
    check("R10 ready with result", {63'd0, inReady}, 64'd1);
    check(req, outResult, exp);
  endtask

  initial begin
    logic [63:0] corners [6];
    logic [63:0] held;
    corners[0] = 64'h0;
    corners[1] = 64'h1;
    corners[2] = 64'hFFFF_FFFF;
    corners[3] = 64'h8000_0000;
    corners[4] = 64'h7FFF_FFFF;
    corners[5] = 64'h0001_0003;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid after reset", {63'd0, outValid}, 64'd0);
    check("R1 ready after reset", {63'd0, inReady}, 64'd1);
    check("R1 result after reset", outResult, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // corner sweep, back to back (R10), both kinds and both widths
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int m = 0; m < 4; m++)
          runOp(corners[i], corners[j], nextRand(), m[0], m[1],
                m[0] ? (m[1] ? "R5 R7 sub wide" : "R5 R7 sub narrow")
                     : (m[1] ? "R4 R7 add wide" : "R4 R7 add narrow"));

    // upper operand bits ignored (R6)
    for (int i = 0; i < 40; i++) begin
      logic [63:0] a, b, c;
      a = nextRand(); b = nextRand(); c = nextRand();
      runOp(a, b, c, i[0], i[1], "R6 upper bits");
      held = outResult;
      @(posedge clk); @(negedge clk);
      runOp({~a[63:32], a[31:0]}, {~b[63:32], b[31:0]}, {~c[63:32], c[31:0]},
            i[0], i[1], "R6 upper bits flipped");
      check("R6 same result", outResult, held);
    end

    // random sweep
    for (int i = 0; i < 300; i++)
      runOp(nextRand(), nextRand(), nextRand(), i[0], i[2], "R4 R5 random");

    // wrap cases
    runOp(64'hFFFF_FFFF, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1'b0, 1'b1, "R4 wrap add");
    runOp(64'h2, 64'h3, 64'h5, 1'b1, 1'b1, "R5 wrap sub wide");
    runOp(64'h2, 64'h3, 64'h5, 1'b1, 1'b0, "R5 wrap sub narrow");

    // hold (R8)
    held = outResult;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); @(negedge clk);
      check("R3 R8 no extra valid", {63'd0, outValid}, 64'd0);
      check("R8 result held", outResult, held);
    end

    // reset mid operation (R9)
    opA = 64'h1234; opB = 64'h5678; opAcc = 64'h9; inValid = 1'b1;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    @(posedge clk); @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R9 ready after reset", {63'd0, inReady}, 64'd1);
    check("R9 result cleared", outResult, 64'd0);
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); @(negedge clk);
      check("R9 no valid after drop", {63'd0, outValid}, 64'd0);
    end
    runOp(64'h10, 64'h10, 64'h1, 1'b0, 1'b0, "R9 R4 after reset");

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule